// File: doc/BRIEF.md
# Ping-Pong Receive DMA Status Tracker

This block sits between a serial receive FIFO and a memory write port. It fills two alternating receive buffers, A and B. Software arms each buffer by strobing a load with a byte length. The engine then moves FIFO entries into whichever buffer is being served, one write strobe per byte. When the served buffer has taken its full length, the engine turns to the other buffer if that one is armed.

Each FIFO entry carries a byte and two error flags, for parity and framing. Each buffer keeps sticky copies of those flags, plus its own overrun flag, and a load of that buffer clears them. An active-low slave-select input is also watched. Each time it deasserts, the byte count of the buffer in service is saved. A 3-bit code records which buffer that count belongs to and whether the deassertion happened more than once. Everything is read through one packed status word.

Both data paths use valid/ready. A byte moves only in a cycle where `fifo_valid`, `wr_ready` and an armed buffer are all present. `fifo_ready` offers a pop only when a buffer is armed and the write port is ready. `wr_valid` offers a write only when a buffer is armed and the FIFO holds a byte. A stalled write port therefore stalls the FIFO.

Top module: `rxdma_pingpong`

## Requirements
- R1: After `rst_n` is released, `status`, `saved_cnt` and `fifo_ready` are all 0, and buffer A is the first to be served.
- R2: Status layout is as follows. Bits [1:0] show receive-active for A and B. Bits [3:2] mirror `tx_active` [A,B]. Bits [5:4] are overrun A/B, [7:6] parity A/B and [9:8] frame A/B. Bits [12:10] hold the slave-select code. Bits [31:13] read 0.
- R3: A load with a nonzero length makes that buffer active on the next cycle, and a zero length leaves it inactive. The buffer then accepts exactly that many bytes, with `wr_idx` running 0,1,2,… and `wr_buf` naming the buffer (0=A, 1=B). After the last byte it goes inactive.
- R4: A is served first. When the served buffer completes, the other buffer is served if it is armed. If only B is armed, B is served. With neither armed, `fifo_ready` and `wr_valid` are 0.
- R5: `fifo_ready` = (some buffer armed) AND `wr_ready`. `wr_valid` = (some buffer armed) AND `fifo_valid`. With `wr_ready` low, no byte is counted.
- R6: A byte taken with `fifo_par_err` or `fifo_frm_err` set raises the parity or frame bit of the buffer that took it. The bit holds until cleared.
- R7: Loading a buffer clears its own parity, frame and overrun bits and leaves those of the other buffer unchanged.
- R8: A `fifo_ovf` pulse is held pending. It is flagged on the overrun bit of the served buffer in the first cycle in which a buffer is armed and `fifo_valid` is low. This appears in status one cycle after that condition.
- R9: A rising edge on `ssel_n` with code 0 saves the served buffer's count in `saved_cnt`. The code becomes 2 if A is served and 3 if B is served (B is used when neither buffer is armed and B is next).
- R10: A further rising edge before the code is cleared saves the new count. The code becomes 6 for A or 7 for B. Codes 1, 4 and 5 never appear.
- R11: A load of either buffer clears the code to 0 but leaves `saved_cnt` unchanged.
- R12: `rx_rst` clears every status bit except the `tx_active` mirror. It also clears the counts, `saved_cnt` and any pending overrun, and makes A the next buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_rst | input | 1 | Receive engine reset strobe |
| ld_a | input | 1 | Load strobe for buffer A |
| ld_b | input | 1 | Load strobe for buffer B |
| ld_len | input | LEN_W | Length for a load strobe |
| tx_active | input | 2 | Transmit-active flags [B,A], mirrored into status |
| fifo_valid | input | 1 | FIFO holds a byte |
| fifo_ready | output | 1 | Engine pops the FIFO this cycle if valid |
| fifo_data | input | DATA_W | FIFO byte |
| fifo_par_err | input | 1 | Parity error flag of the FIFO byte |
| fifo_frm_err | input | 1 | Frame error flag of the FIFO byte |
| fifo_ovf | input | 1 | FIFO overrun pulse |
| wr_valid | output | 1 | Write request to buffer memory |
| wr_ready | input | 1 | Memory accepts the write |
| wr_buf | output | 1 | Target buffer, 0=A, 1=B |
| wr_idx | output | LEN_W | Byte offset within the buffer |
| wr_data | output | DATA_W | Byte to write |
| ssel_n | input | 1 | Active-low slave select |
| saved_cnt | output | LEN_W | Count saved on slave-select deassertion |
| status | output | 32 | Packed status word |

## Verification
On every cycle the assertions check the following. A buffer's count stays below its length while it is active. Counts and active bits do not move while the port is stalled. Error bits rise only on a flagged byte. The capture code never takes a reserved value and reads 0 after a clear. Only the bench scenarios can show the byte ordering across the two buffers for each length pair, the deferred landing of an overrun, and the 2/3 to 6/7 progression with its saved counts.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int ST_W    = 32;
  localparam int P_RXACT = 0;
  localparam int P_TXACT = 2;
  localparam int P_OVF   = 4;
  localparam int P_PAR   = 6;
  localparam int P_FRM   = 8;
  localparam int P_CODE  = 10;
  localparam int CODE_W  = 3;
  localparam logic BUF_A = 1'b0;
  localparam logic BUF_B = 1'b1;
endpackage

// File: rtl/rxdma_buf.sv
module rxdma_buf #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             take,
  input  logic             take_par,
  input  logic             take_frm,
  input  logic             ovf_set,
  output logic             active,
  output logic             last,
  output logic [LEN_W-1:0] cnt,
  output logic             par,
  output logic             frm,
  output logic             ovf
);
  logic [LEN_W-1:0] len_q;

  assign last = active && (cnt == len_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0; cnt <= '0; active <= 1'b0;
      par <= 1'b0; frm <= 1'b0; ovf <= 1'b0;
    end else if (clr) begin
      len_q <= '0; cnt <= '0; active <= 1'b0;
      par <= 1'b0; frm <= 1'b0; ovf <= 1'b0;
    end else if (load) begin
      len_q  <= load_len;
      cnt    <= '0;
      active <= (load_len != '0);
      par <= 1'b0; frm <= 1'b0; ovf <= 1'b0;
    end else begin
      if (take) begin
        cnt <= cnt + 1'b1;
        if (last) active <= 1'b0;
        par <= par | take_par;
        frm <= frm | take_frm;
      end
      if (ovf_set) ovf <= 1'b1;
    end
  end

  AST_CNT_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < len_q)); // R3

  AST_CNT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !load && !clr) |=> $stable(cnt)); // R5

  AST_PAR_RISE_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par) |-> $past(take && take_par)); // R6

  AST_FRM_RISE_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm) |-> $past(take && take_frm)); // R6

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!par && !frm && !ovf)); // R7
endmodule

// File: rtl/rxdma_ssel_cap.sv
module rxdma_ssel_cap #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_rst,
  input  logic             clr_code,
  input  logic             ssel_n,
  input  logic             cur_buf,
  input  logic [LEN_W-1:0] cur_cnt,
  output logic [2:0]       code,
  output logic [LEN_W-1:0] saved
);
  logic ssel_q;
  logic deassert;

  assign deassert = ssel_n && !ssel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ssel_q <= 1'b1; code <= '0; saved <= '0;
    end else begin
      ssel_q <= ssel_n;
      if (rx_rst) begin
        code <= '0; saved <= '0;
      end else if (clr_code) begin
        code <= '0;
      end else if (deassert) begin
        saved <= cur_cnt;
        code  <= {(code != '0), 1'b1, cur_buf};
      end
    end
  end

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (code != 3'd1) && (code != 3'd4) && (code != 3'd5)); // R10

  AST_CODE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rst || clr_code) |=> (code == '0)); // R11

  AST_SAVED_HELD_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_code && !rx_rst) |=> $stable(saved)); // R11
endmodule

// File: rtl/rxdma_pingpong.sv
module rxdma_pingpong #(
  parameter int LEN_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_rst,
  input  logic              ld_a,
  input  logic              ld_b,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic [1:0]        tx_active,
  input  logic              fifo_valid,
  output logic              fifo_ready,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_par_err,
  input  logic              fifo_frm_err,
  input  logic              fifo_ovf,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              wr_buf,
  output logic [LEN_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  input  logic              ssel_n,
  output logic [LEN_W-1:0]  saved_cnt,
  output logic [31:0]       status
);
  import rxdma_pkg::*;
  localparam int NBUF = 2;

  logic [NBUF-1:0]  act, lst, par, frm, ovf, take, load, ovf_set;
  logic [LEN_W-1:0] cnt [NBUF];
  logic             nxt_q, srv, armed, xfer, ovf_pend, ovf_hit;
  logic [2:0]       code;

  assign armed      = |act;
  assign srv        = act[nxt_q] ? nxt_q : (act[~nxt_q] ? ~nxt_q : nxt_q);
  assign fifo_ready = armed && wr_ready;
  assign wr_valid   = armed && fifo_valid;
  assign xfer       = fifo_valid && fifo_ready;
  assign wr_buf     = srv;
  assign wr_idx     = cnt[srv];
  assign wr_data    = fifo_data;
  assign ovf_hit    = ovf_pend && armed && !fifo_valid;

  assign load = {ld_b, ld_a};

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    assign take[g]    = xfer && (srv == g[0]);
    assign ovf_set[g] = ovf_hit && (srv == g[0]);
    rxdma_buf #(.LEN_W(LEN_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr(rx_rst),
      .load(load[g]), .load_len(ld_len),
      .take(take[g]), .take_par(fifo_par_err), .take_frm(fifo_frm_err),
      .ovf_set(ovf_set[g]),
      .active(act[g]), .last(lst[g]), .cnt(cnt[g]),
      .par(par[g]), .frm(frm[g]), .ovf(ovf[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_q <= BUF_A; ovf_pend <= 1'b0;
    end else if (rx_rst) begin
      nxt_q <= BUF_A; ovf_pend <= 1'b0;
    end else begin
      if (xfer && lst[srv]) nxt_q <= ~srv;
      if (fifo_ovf)         ovf_pend <= 1'b1;
      else if (ovf_hit)     ovf_pend <= 1'b0;
    end
  end

  rxdma_ssel_cap #(.LEN_W(LEN_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .rx_rst(rx_rst),
    .clr_code(ld_a || ld_b), .ssel_n(ssel_n),
    .cur_buf(srv), .cur_cnt(cnt[srv]),
    .code(code), .saved(saved_cnt)
  );

  always_comb begin
    status = '0;
    status[P_RXACT +: 2]      = act;
    status[P_TXACT +: 2]      = tx_active;
    status[P_OVF   +: 2]      = ovf;
    status[P_PAR   +: 2]      = par;
    status[P_FRM   +: 2]      = frm;
    status[P_CODE  +: CODE_W] = code;
  end

  AST_NO_MOVE_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_ready && !ld_a && !ld_b && !rx_rst) |=> $stable(act)); // R5

  AST_RX_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |=> (status[12:4] == '0 && act == '0 && saved_cnt == '0)); // R12

  AST_NO_WRITE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!wr_valid && !fifo_ready)); // R4
endmodule

// File: tb/sim_rxdma_pingpong.sv
module sim_rxdma_pingpong;
  localparam int CLK_P = 10;
  localparam int LW = 8;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0, rx_rst = 1'b0, ld_a = 1'b0, ld_b = 1'b0;
  logic [LW-1:0] ld_len = '0;
  logic [1:0] tx_active = '0;
  logic fifo_valid = 1'b0, fifo_par_err = 1'b0, fifo_frm_err = 1'b0, fifo_ovf = 1'b0;
  logic [DW-1:0] fifo_data = '0;
  logic wr_ready = 1'b1, ssel_n = 1'b1;
  logic fifo_ready, wr_valid, wr_buf;
  logic [LW-1:0] wr_idx, saved_cnt;
  logic [DW-1:0] wr_data;
  logic [31:0] status;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  rxdma_pingpong #(.LEN_W(LW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_rst(rx_rst), .ld_a(ld_a), .ld_b(ld_b),
    .ld_len(ld_len), .tx_active(tx_active), .fifo_valid(fifo_valid),
    .fifo_ready(fifo_ready), .fifo_data(fifo_data), .fifo_par_err(fifo_par_err),
    .fifo_frm_err(fifo_frm_err), .fifo_ovf(fifo_ovf), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_buf(wr_buf), .wr_idx(wr_idx), .wr_data(wr_data),
    .ssel_n(ssel_n), .saved_cnt(saved_cnt), .status(status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_rxrst();
    rx_rst = 1'b1; @(negedge clk); rx_rst = 1'b0;
  endtask

  task automatic do_load(input logic b, input int len);
    ld_len = LW'(len);
    if (b) ld_b = 1'b1; else ld_a = 1'b1;
    @(negedge clk);
    ld_a = 1'b0; ld_b = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic p, input logic f,
                      input logic eb, input int ei, input string tag);
    fifo_valid = 1'b1; fifo_data = d; fifo_par_err = p; fifo_frm_err = f;
    #1;
    chk({tag, " wr_valid"}, 32'(wr_valid), 32'd1);
    chk({tag, " wr_buf"}, 32'(wr_buf), 32'(eb));
    chk({tag, " wr_idx"}, 32'(wr_idx), 32'(ei));
    chk({tag, " wr_data"}, 32'(wr_data), 32'(d));
    @(negedge clk);
    fifo_valid = 1'b0; fifo_par_err = 1'b0; fifo_frm_err = 1'b0;
  endtask

  task automatic ssel_pulse();
    ssel_n = 1'b0; @(negedge clk); ssel_n = 1'b1; @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", status, 32'd0);
    chk("R1 saved", 32'(saved_cnt), 32'd0);
    chk("R1 fifo_ready", 32'(fifo_ready), 32'd0);

    // R2 tx mirror and zero upper bits
    tx_active = 2'b10; #1;
    chk("R2 tx bits", status, 32'h8);
    tx_active = 2'b00;

    // R3 R4 sweep over length pairs
    for (int la = 1; la <= 3; la++) begin
      for (int lb = 1; lb <= 3; lb++) begin
        do_rxrst();
        do_load(1'b0, la);
        do_load(1'b1, lb);
        chk("R3 both active", status[1:0], 2'b11);
        for (int i = 0; i < la + lb; i++)
          push(8'(i * 7 + la), 1'b0, 1'b0, (i < la) ? 1'b1 == 1'b0 : 1'b1,
               (i < la) ? i : i - la, "R4 order");
        chk("R3 done inactive", status[1:0], 2'b00);
        chk("R4 idle ready", 32'(fifo_ready), 32'd0);
      end
    end

    // R3 zero length, R4 only B
    do_rxrst();
    do_load(1'b0, 0);
    chk("R3 zero length", status[0], 1'b0);
    do_load(1'b1, 2);
    push(8'h11, 1'b0, 1'b0, 1'b1, 0, "R4 only B");

    // R5 back-pressure
    do_rxrst();
    do_load(1'b0, 2);
    wr_ready = 1'b0; fifo_valid = 1'b1; #1;
    chk("R5 ready low", 32'(fifo_ready), 32'd0);
    chk("R5 wr_valid", 32'(wr_valid), 32'd1);
    @(negedge clk); @(negedge clk);
    chk("R5 no count", 32'(wr_idx), 32'd0);
    fifo_valid = 1'b0; wr_ready = 1'b1;
    push(8'h22, 1'b0, 1'b0, 1'b0, 0, "R5 resume");

    // R6 R7 error bits
    do_rxrst();
    do_load(1'b0, 2);
    do_load(1'b1, 2);
    push(8'h01, 1'b1, 1'b0, 1'b0, 0, "R6 par A");
    chk("R6 par A set", status[7:6], 2'b01);
    push(8'h02, 1'b0, 1'b0, 1'b0, 1, "R6 clean A");
    push(8'h03, 1'b0, 1'b1, 1'b1, 0, "R6 frm B");
    chk("R6 frm B set", status[9:8], 2'b10);
    chk("R6 par A sticky", status[7:6], 2'b01);
    do_load(1'b0, 1);
    chk("R7 par A cleared", status[7:6], 2'b00);
    chk("R7 frm B kept", status[9:8], 2'b10);

    // R8 overrun deferred until armed and FIFO empty
    do_rxrst();
    fifo_ovf = 1'b1; @(negedge clk); fifo_ovf = 1'b0;
    @(negedge clk);
    chk("R8 no buffer yet", status[5:4], 2'b00);
    do_load(1'b0, 2);
    @(negedge clk);
    chk("R8 ovf on A", status[5:4], 2'b01);
    do_load(1'b0, 2);
    chk("R7 ovf cleared", status[5:4], 2'b00);

    // R9 R10 R11 slave-select capture
    do_rxrst();
    do_load(1'b0, 3);
    do_load(1'b1, 2);
    push(8'h31, 1'b0, 1'b0, 1'b0, 0, "R9 A0");
    push(8'h32, 1'b0, 1'b0, 1'b0, 1, "R9 A1");
    ssel_pulse();
    chk("R9 code A", status[12:10], 3'd2);
    chk("R9 saved", 32'(saved_cnt), 32'd2);
    push(8'h33, 1'b0, 1'b0, 1'b0, 2, "R9 A2");
    push(8'h34, 1'b0, 1'b0, 1'b1, 0, "R9 B0");
    ssel_pulse();
    chk("R10 code B repeat", status[12:10], 3'd7);
    chk("R10 saved", 32'(saved_cnt), 32'd1);
    do_load(1'b0, 1);
    chk("R11 code cleared", status[12:10], 3'd0);
    chk("R11 saved kept", 32'(saved_cnt), 32'd1);
    ssel_pulse();
    chk("R9 code B single", status[12:10], 3'd3);
    do_rxrst();
    chk("R12 status", status, 32'd0);
    chk("R12 saved", 32'(saved_cnt), 32'd0);
    do_load(1'b0, 1);
    do_load(1'b1, 1);
    push(8'h44, 1'b0, 1'b0, 1'b0, 0, "R12 A next");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule